// File: doc/BRIEF.md
# Eight-Bit Bidirectional I/O Port with Emulation Pass-Through

The block is an eight-bit general-purpose I/O port on a microcontroller's register bus. A direction register picks, bit by bit, whether a pad is driven or left as a high-impedance input. A data register holds the values to drive. Pad levels are brought into the bus clock domain through a two-flop chain per bit. The lowest two bits are wired as input-only lines: they can never be driven, and their value comes from the pads once the synchronizer has filled after reset.

Software uses a one-bit address (0 selects data, 1 selects direction) and a single-cycle write strobe. Read data is returned combinationally in the same cycle. When the emulation input is high, reads return whatever the external bus presents. Writes still update the internal registers, and they are also copied out to the external bus in the same cycle as the strobe.

The asynchronous active-low reset is asserted at once and released through a two-stage synchronizer inside the block.

Top module: `gpio_port_emu`

## Requirements
- R1: A write strobe with address 1 loads the direction register on the next rising edge. From then on `pad_oe_o` equals the written value with bits 1:0 forced to 0, and `pad_out_o` equals the data register.
- R2: While reset is applied, both registers read as 0 and `pad_oe_o` and `pad_out_o` are all zero, so every pad is an input.
- R3: With emulation off and address 0, each read data bit is the data register bit where the direction bit is 1, and the synchronized pad level where it is 0. A pad change appears after the second rising edge that follows it, not after the first.
- R4: With emulation off and address 1, read data returns the direction register.
- R5: With emulation on, read data equals `ext_rdata_i` for either address.
- R6: With emulation on, a write strobe raises `ext_wr_o` in the same cycle, with `ext_addr_o` and `ext_wdata_o` copied from the request, and the internal register is still updated. With emulation off, `ext_wr_o` stays low.
- R7: Bits 1:0 are input-only. Writes to them are ignored, their output enable is always 0, and their direction bits read 0. After `rst_n` is deasserted they read 0 through the third rising edge and follow the pads from the fourth rising edge on.
- R8: In a cycle with no write strobe, neither register changes, whatever the address or write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| emu_mode_i | input | 1 | Emulation mode select |
| reg_wr_i | input | 1 | Single-cycle write strobe |
| reg_addr_i | input | 1 | 0 = data register, 1 = direction register |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Combinational read data |
| ext_rdata_i | input | 8 | Read data from the external bus |
| ext_wr_o | output | 1 | Write strobe copied to the external bus |
| ext_addr_o | output | 1 | Address copied to the external bus |
| ext_wdata_o | output | 8 | Write data copied to the external bus |
| pad_in_i | input | 8 | Pad input levels (asynchronous) |
| pad_out_o | output | 8 | Pad output values |
| pad_oe_o | output | 8 | Pad output enables, 1 = drive |

## Verification
The bench uses the default parameters: eight bits wide, two input-only bits and two synchronizer stages. With these values the four-edge release of the input-only bits and the two-edge lag of a pad change land on exact, countable cycles that the bench checks. The narrow width lets random data and direction values mix driven and sampled bits in every possible split. Random emulation cycles are interleaved with normal ones, so reads switch back and forth between the external bus and the internal registers.

// File: rtl/gpio_emu_pkg.sv
package gpio_emu_pkg;
  // Register select on the one-bit address; the encoding is visible to software.
  typedef enum logic {
    SEL_DATA = 1'b0,
    SEL_DIR  = 1'b1
  } port_sel_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_sync_bank.sv
module gpio_sync_bank #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] ff_q;
    logic [STAGES-1:0] ff_d;

    always_comb begin
      ff_d = {ff_q[STAGES-2:0], async_i[b]};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ff_q <= '0;
      end else begin
        ff_q <= ff_d;
      end
    end

    assign sync_o[b] = ff_q[STAGES-1];
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_emu_pkg::*;
#(
  parameter int               WIDTH   = 8,
  parameter logic [WIDTH-1:0] WR_MASK = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  port_sel_e        sel_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] data_o,
  output logic [WIDTH-1:0] dir_o
);
  logic [WIDTH-1:0] data_q, data_d;
  logic [WIDTH-1:0] dir_q, dir_d;
  logic             data_en, dir_en;

  always_comb begin
    data_en = wr_en_i && (sel_i == SEL_DATA);
    dir_en  = wr_en_i && (sel_i == SEL_DIR);
    data_d  = wdata_i & WR_MASK;
    dir_d   = wdata_i & WR_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      if (data_en) data_q <= data_d;
      if (dir_en)  dir_q  <= dir_d;
    end
  end

  assign data_o = data_q;
  assign dir_o  = dir_q;
endmodule

// File: rtl/gpio_port_emu.sv
module gpio_port_emu
  import gpio_emu_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int IN_ONLY     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_n,
  input  logic             emu_mode_i,
  input  logic             reg_wr_i,
  input  logic             reg_addr_i,
  input  logic [WIDTH-1:0] reg_wdata_i,
  output logic [WIDTH-1:0] reg_rdata_o,
  input  logic [WIDTH-1:0] ext_rdata_i,
  output logic             ext_wr_o,
  output logic             ext_addr_o,
  output logic [WIDTH-1:0] ext_wdata_o,
  input  logic [WIDTH-1:0] pad_in_i,
  output logic [WIDTH-1:0] pad_out_o,
  output logic [WIDTH-1:0] pad_oe_o
);
  // Bits below IN_ONLY can never be driven.
  localparam logic [WIDTH-1:0] OUT_MASK = {WIDTH{1'b1}} << IN_ONLY;

  logic             core_rst_n;
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] data_q;
  logic [WIDTH-1:0] dir_q;
  port_sel_e        sel;

  assign sel = port_sel_e'(reg_addr_i);

  gpio_rst_sync #(.STAGES(SYNC_STAGES)) rst_sync_i (
    .clk_i    (clk_i),
    .arst_n_i (rst_n),
    .rst_n_o  (core_rst_n)
  );

  gpio_sync_bank #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
    .clk_i   (clk_i),
    .rst_ni  (core_rst_n),
    .async_i (pad_in_i),
    .sync_o  (pin_sync)
  );

  gpio_port_regs #(.WIDTH(WIDTH), .WR_MASK(OUT_MASK)) regs_i (
    .clk_i   (clk_i),
    .rst_ni  (core_rst_n),
    .wr_en_i (reg_wr_i),
    .sel_i   (sel),
    .wdata_i (reg_wdata_i),
    .data_o  (data_q),
    .dir_o   (dir_q)
  );

  always_comb begin
    if (emu_mode_i) begin
      reg_rdata_o = ext_rdata_i;
    end else if (sel == SEL_DIR) begin
      reg_rdata_o = dir_q;
    end else begin
      reg_rdata_o = (data_q & dir_q) | (pin_sync & ~dir_q);
    end
  end

  assign ext_wr_o    = reg_wr_i & emu_mode_i;
  assign ext_addr_o  = reg_addr_i;
  assign ext_wdata_o = reg_wdata_i;

  assign pad_out_o = data_q;
  assign pad_oe_o  = dir_q;
endmodule

// File: rtl/gpio_port_emu_chk.sv
module gpio_port_emu_chk #(
  parameter int WIDTH   = 8,
  parameter int IN_ONLY = 2
) (
  input logic             clk_i,
  input logic             core_rst_n,
  input logic             emu_mode_i,
  input logic             reg_wr_i,
  input logic             reg_addr_i,
  input logic [WIDTH-1:0] reg_wdata_i,
  input logic [WIDTH-1:0] reg_rdata_o,
  input logic [WIDTH-1:0] ext_rdata_i,
  input logic             ext_wr_o,
  input logic             ext_addr_o,
  input logic [WIDTH-1:0] ext_wdata_o,
  input logic [WIDTH-1:0] pad_out_o,
  input logic [WIDTH-1:0] pad_oe_o
);
  localparam logic [WIDTH-1:0] MASK = {WIDTH{1'b1}} << IN_ONLY;

  // R1
  dir_write_chk: assert property (@(posedge clk_i) disable iff (!core_rst_n)
    (reg_wr_i && reg_addr_i) |=> (pad_oe_o == ($past(reg_wdata_i) & MASK)));

  // R1
  data_write_chk: assert property (@(posedge clk_i) disable iff (!core_rst_n)
    (reg_wr_i && !reg_addr_i) |=> (pad_out_o == ($past(reg_wdata_i) & MASK)));

  // R4
  dir_read_chk: assert property (@(posedge clk_i) disable iff (!core_rst_n)
    (!emu_mode_i && reg_addr_i) |-> (reg_rdata_o == pad_oe_o));

  // R5
  emu_read_chk: assert property (@(posedge clk_i) disable iff (!core_rst_n)
    emu_mode_i |-> (reg_rdata_o == ext_rdata_i));

  // R6
  emu_mirror_chk: assert property (@(posedge clk_i) disable iff (!core_rst_n)
    (emu_mode_i && reg_wr_i) |->
      (ext_wr_o && ext_addr_o == reg_addr_i && ext_wdata_o == reg_wdata_i));

  // R6
  no_mirror_chk: assert property (@(posedge clk_i) disable iff (!core_rst_n)
    !emu_mode_i |-> !ext_wr_o);

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!core_rst_n)
    !reg_wr_i |=> ($stable(pad_out_o) && $stable(pad_oe_o)));
endmodule

bind gpio_port_emu gpio_port_emu_chk #(.WIDTH(WIDTH), .IN_ONLY(IN_ONLY)) chk_i (
  .clk_i       (clk_i),
  .core_rst_n  (core_rst_n),
  .emu_mode_i  (emu_mode_i),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .ext_rdata_i (ext_rdata_i),
  .ext_wr_o    (ext_wr_o),
  .ext_addr_o  (ext_addr_o),
  .ext_wdata_o (ext_wdata_o),
  .pad_out_o   (pad_out_o),
  .pad_oe_o    (pad_oe_o)
);

// File: tb/gpio_port_emu_tb_top.sv
module gpio_port_emu_tb_top;
  localparam logic [7:0] MASK = 8'hFC;

  logic       clk_i = 1'b0;
  logic       rst_n;
  logic       emu_mode_i, reg_wr_i, reg_addr_i;
  logic [7:0] reg_wdata_i, reg_rdata_o, ext_rdata_i, ext_wdata_o;
  logic       ext_wr_o, ext_addr_o;
  logic [7:0] pad_in_i, pad_out_o, pad_oe_o;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  logic [7:0] m_data, m_dir, m_pins;

  always #5 clk_i = ~clk_i;

  gpio_port_emu dut_i (
    .clk_i(clk_i), .rst_n(rst_n), .emu_mode_i(emu_mode_i),
    .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .ext_rdata_i(ext_rdata_i), .ext_wr_o(ext_wr_o),
    .ext_addr_o(ext_addr_o), .ext_wdata_o(ext_wdata_o), .pad_in_i(pad_in_i),
    .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(logic a, logic e, logic [7:0] x, logic [7:0] pins);
    if (e) return x;
    if (a) return m_dir;
    return (m_data & m_dir) | (pins & ~m_dir);
  endfunction

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(logic wr, logic a, logic [7:0] wd, logic e, logic [7:0] x);
    reg_wr_i = wr; reg_addr_i = a; reg_wdata_i = wd; emu_mode_i = e; ext_rdata_i = x;
    #1;
    check(e ? "R5 read" : (a ? "R4 read" : "R3 read"), reg_rdata_o, exp_read(a, e, x, m_pins));
    check("R6 ext_wr", {7'd0, ext_wr_o}, {7'd0, wr & e});
    if (wr && e) begin
      check("R6 ext_wdata", ext_wdata_o, wd);
      check("R6 ext_addr", {7'd0, ext_addr_o}, {7'd0, a});
    end
    @(posedge clk_i);
    if (wr) begin
      if (a) m_dir = wd & MASK;
      else   m_data = wd & MASK;
    end
    @(negedge clk_i);
    reg_wr_i = 1'b0;
    check(wr ? "R1 pad_oe" : "R8 pad_oe", pad_oe_o, m_dir);
    check(wr ? "R1 pad_out" : "R8 pad_out", pad_out_o, m_data);
  endtask

  task automatic pins_change(logic [7:0] nv);
    reg_wr_i = 1'b0; reg_addr_i = 1'b0; emu_mode_i = 1'b0; pad_in_i = nv;
    @(posedge clk_i); @(negedge clk_i);
    check("R3 one edge old", reg_rdata_o, exp_read(1'b0, 1'b0, 8'h00, m_pins));
    @(posedge clk_i); @(negedge clk_i);
    m_pins = nv;
    check("R3 two edges new", reg_rdata_o, exp_read(1'b0, 1'b0, 8'h00, m_pins));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; emu_mode_i = 1'b0; reg_wr_i = 1'b0; reg_addr_i = 1'b0;
    reg_wdata_i = 8'h00; ext_rdata_i = 8'h00; pad_in_i = 8'hA7;
    m_data = 8'h00; m_dir = 8'h00; m_pins = 8'hA7;
    repeat (3) @(negedge clk_i);
    check("R2 rdata in reset", reg_rdata_o, 8'h00);
    check("R2 pad_oe in reset", pad_oe_o, 8'h00);
    check("R2 pad_out in reset", pad_out_o, 8'h00);
    reg_addr_i = 1'b1; #1;
    check("R2 dir in reset", reg_rdata_o, 8'h00);
    reg_addr_i = 1'b0;
    rst_n = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      @(posedge clk_i); @(negedge clk_i);
      check("R7 input-only still zero", {6'd0, reg_rdata_o[1:0]}, 8'h00);
    end
    @(posedge clk_i); @(negedge clk_i);
    check("R7 input-only loaded", reg_rdata_o, 8'hA7);

    // Directed corners
    step(1'b1, 1'b1, 8'hFF, 1'b0, 8'h00);   // R7: dir bits 1:0 ignored
    step(1'b0, 1'b1, 8'h00, 1'b0, 8'h00);   // R4 readback of FC
    step(1'b1, 1'b0, 8'h5A, 1'b0, 8'h00);   // R7: data bits 1:0 ignored
    step(1'b0, 1'b0, 8'hFF, 1'b0, 8'h00);   // R3/R8 mixed read 5B
    step(1'b1, 1'b0, 8'h3C, 1'b1, 8'h99);   // R6 mirror + internal update, R5
    step(1'b0, 1'b1, 8'h00, 1'b1, 8'h42);   // R5 dir address in emulation
    step(1'b1, 1'b1, 8'h0F, 1'b0, 8'h00);   // R1 partial direction
    pins_change(8'h5C);                      // R3 two-edge lag
    step(1'b1, 1'b1, 8'h00, 1'b0, 8'h00);   // R3 all inputs
    step(1'b0, 1'b0, 8'hAA, 1'b0, 8'h00);   // R8 junk write data, no strobe

    for (int i = 0; i < 400; i++) begin
      if ($urandom % 8 == 0) pins_change(8'($urandom));
      else step(1'($urandom), 1'($urandom), 8'($urandom),
                ($urandom % 4) == 0, 8'($urandom));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule